// File: doc/BRIEF.md
# MDIO Management Access Controller

This block lets host software reach the management registers of Ethernet PHYs over a two-wire MDC/MDIO bus. Software sees two 32-bit registers: a control register and a value register. The control register holds a target PHY address, a register index, a direction flag and a busy flag. The value register holds the 16-bit word that goes out to the PHY, or the word that comes back from it. Writing the control register with the busy flag set launches one clause-22 management frame. The block divides the system clock down to MDC, shifts the frame out MSB first, and releases MDIO for the turnaround and data phases of a read. It clears the busy flag by itself once the last bit has gone by.

Software polls the busy flag and touches neither register until it reads 0. While a frame is running, the block ignores host writes to both registers, so a stray write cannot corrupt the frame on the wire. The on-chip PHY answers at management address 1; every other address reaches external PHYs on the same pair of wires. The controller treats all addresses the same way.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset both registers read 0x00000000, and MDC, MDIO output and MDIO output enable are all low.
- R2: The control register (reg_sel=0) keeps the PHY address in bits 15:11, the register index in bits 10:6, the direction flag in bit 1 (1 = write to PHY) and the busy flag in bit 0. Bits 31:16 and 5:2 read as zero, so writing all ones with busy 0 reads back 0x0000FFC2.
- R3: Writing the control register with bit 0 set while idle starts a frame. Busy then reads 1 for exactly 128*DIV_HALF clock cycles and returns to 0 by itself. The frame is 64 MDC periods, each with a low half and a high half of DIV_HALF clocks.
- R4: A write frame sent MSB first and sampled at rising MDC is 32 ones, 01, opcode 01, the 5-bit address, the 5-bit index, turnaround 10 and the 16 data bits. The output enable is high for all 64 bits.
- R5: A read frame carries opcode 10. The output enable is high for bits 0 to 45 and low from the first turnaround bit (bit 46) through bit 63.
- R6: On a read, the 16 MDIO values sampled at the rising MDC edges of bits 48 to 63 appear MSB first in value register bits 15:0 once busy reads 0.
- R7: The value register (reg_sel=1) stores only bits 15:0. Bits 31:16 read as zero.
- R8: While busy is 1, host writes to both registers are ignored. The address, index, direction and value keep their prior contents, and the frame on the wire is unaffected.
- R9: When idle, MDC stays low and the output enable is low. During a frame, MDIO output changes only while MDC is low; it never changes during an MDC high half.
- R10: Writing the control register with bit 0 clear only stores the fields and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select: 0 control, 1 value |
| reg_we | input | 1 | Host write strobe |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value from the bus |

## Verification
The hardest case to reach from the ports is a host write that arrives in the middle of a running frame. The block must drop it, while the frame bits already on the wire and the read data being sampled stay intact. The stimulus fires writes to both registers at a random clock offset inside each random transaction. It then compares the whole captured frame and the final register contents against values that bench functions compute. A model PHY in the bench follows the MDC edges and drives read data after each falling edge, so capture on the rising edge is exercised in every read.

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int FRAME_BITS = 64;
  localparam int TA_BIT = 46;
  localparam int DATA_BIT = 48;

  logic [4:0]  phy_q, idx_q;
  logic        wr_q, busy_q, mdc_q, oe_q;
  logic [15:0] data_q;
  logic [CW-1:0] cnt_q;
  logic [5:0]  bit_q;
  logic [63:0] sh_q;

  wire tick  = busy_q && (cnt_q == CW'(DIV_HALF - 1));
  wire start = reg_we && !reg_sel && !busy_q && reg_wdata[0];
  wire wsel  = reg_wdata[1];
  wire [63:0] frame = {32'hFFFF_FFFF, 2'b01, wsel ? 2'b01 : 2'b10,
                       reg_wdata[15:11], reg_wdata[10:6],
                       wsel ? 2'b10 : 2'b00, wsel ? data_q : 16'h0000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phy_q <= '0; idx_q <= '0; wr_q <= 1'b0; busy_q <= 1'b0;
      data_q <= '0; cnt_q <= '0; bit_q <= '0; mdc_q <= 1'b0;
      oe_q <= 1'b0; sh_q <= '0;
    end else begin
      if (reg_we && !busy_q) begin
        if (!reg_sel) begin
          phy_q  <= reg_wdata[15:11];
          idx_q  <= reg_wdata[10:6];
          wr_q   <= reg_wdata[1];
          busy_q <= reg_wdata[0];
        end else begin
          data_q <= reg_wdata[15:0];
        end
      end
      if (start) begin
        cnt_q <= '0;
        bit_q <= '0;
        mdc_q <= 1'b0;
        sh_q  <= frame;
        oe_q  <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= tick ? '0 : cnt_q + 1'b1;
        if (tick) begin
          if (!mdc_q) begin
            mdc_q <= 1'b1;
            if (!wr_q && bit_q >= 6'(DATA_BIT))
              data_q <= {data_q[14:0], mdio_i};
          end else begin
            mdc_q <= 1'b0;
            if (bit_q == 6'(FRAME_BITS - 1)) begin
              busy_q <= 1'b0;
              oe_q   <= 1'b0;
              sh_q   <= '0;
            end else begin
              bit_q <= bit_q + 1'b1;
              sh_q  <= {sh_q[62:0], 1'b0};
              if (!wr_q && bit_q == 6'(TA_BIT - 1))
                oe_q <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign reg_rdata = reg_sel ? {16'h0000, data_q}
                             : {16'h0000, phy_q, idx_q, 4'b0000, wr_q, busy_q};
  assign mdc     = mdc_q;
  assign mdio_o  = sh_q[63];
  assign mdio_oe = oe_q;

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc_q && !oe_q));
  p_ta_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !wr_q && bit_q >= 6'(TA_BIT)) |-> !oe_q);
  p_write_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_q) |-> oe_q);
  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_q) |=> $stable(data_q));
  p_hold_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable({phy_q, idx_q, wr_q}));
  p_done_after_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(bit_q) == 6'(FRAME_BITS - 1) && !mdc_q));
  p_mdio_hold_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_q && $past(mdc_q)) |-> $stable(sh_q[63]));
endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;
  localparam int DIV_HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_we = 1'b0, mdio_i = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mdc, mdio_o, mdio_oe;

  int total = 0, bad = 0;
  int rises = 0, falls = 0, fall0 = 0, viol = 0;
  logic [63:0] cap = '0, oecap = '0;
  logic [15:0] phy_val = '0;
  logic last_mdc = 1'b0, last_o = 1'b0;
  bit done = 1'b0;

  mdio_mgmt_ctrl #(.DIV_HALF(DIV_HALF)) dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #5 clk = ~clk;

  always @(posedge mdc) begin
    cap   = {cap[62:0], mdio_o};
    oecap = {oecap[62:0], mdio_oe};
    rises = rises + 1;
  end

  always @(negedge mdc) begin
    int b;
    falls = falls + 1;
    b = falls - fall0;
    if (b >= 48 && b <= 63) mdio_i = phy_val[63 - b];
  end

  always @(negedge clk) begin
    if (mdc && last_mdc && mdio_o != last_o) viol = viol + 1;
    last_mdc = mdc;
    last_o = mdio_o;
  end

  function automatic logic [63:0] exp_frame(logic w, logic [4:0] pa, logic [4:0] ra, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, w ? 2'b01 : 2'b10, pa, ra, w ? 2'b10 : 2'b00, w ? d : 16'h0000};
  endfunction

  function automatic logic [63:0] exp_oe(logic w);
    return w ? {64{1'b1}} : {{46{1'b1}}, 18'h0};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic sel, logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic hread(logic sel, output logic [31:0] d);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic run_txn(logic w, logic [4:0] pa, logic [4:0] ra, logic [15:0] d, logic [15:0] pv, int poke);
    logic [31:0] r;
    logic [31:0] acc;
    int n;
    int r0;
    acc = {16'h0, pa, ra, 4'h0, w, 1'b1};
    phy_val = pv;
    hwrite(1'b1, {16'hA5A5, d});
    fall0 = falls;
    r0 = rises;
    hwrite(1'b0, acc);
    n = 1;
    while (1) begin
      if (n == poke) begin
        reg_sel = 1'b0; reg_wdata = ~acc; reg_we = 1'b1;
        @(negedge clk); n++;
        reg_sel = 1'b1; reg_wdata = ~{16'h0, d}; reg_we = 1'b1;
        @(negedge clk); n++;
        reg_we = 1'b0;
      end
      hread(1'b0, r);
      if (r[0] == 1'b0) break;
      @(negedge clk); n++;
      if (n > 4000) break;
    end
    check("R3 busy duration", 64'(n), 64'(128 * DIV_HALF + 1));
    check("R3 rise count", 64'(rises - r0), 64'd64);
    if (w) check("R4 write frame", cap, exp_frame(1'b1, pa, ra, d));
    else   check("R5 read header", {cap[63:18], 18'h0}, exp_frame(1'b0, pa, ra, 16'h0));
    check(w ? "R4 oe" : "R5 oe", oecap, exp_oe(w));
    hread(1'b0, r);
    check("R8 access kept", 64'(r), 64'({16'h0, pa, ra, 4'h0, w, 1'b0}));
    hread(1'b1, r);
    check(w ? "R8 data kept" : "R6 read data", 64'(r), 64'({16'h0, w ? d : pv}));
    check("R9 idle mdc/oe", {62'h0, mdc, mdio_oe}, 64'h0);
  endtask

  initial begin
    logic [31:0] r;
    int seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    hread(1'b0, r); check("R1 access reset", 64'(r), 64'h0);
    hread(1'b1, r); check("R1 data reset", 64'(r), 64'h0);
    check("R1 pins", {61'h0, mdc, mdio_o, mdio_oe}, 64'h0);

    hwrite(1'b0, 32'hFFFF_FFFE);
    hread(1'b0, r); check("R2 layout", 64'(r), 64'h0000_FFC2);
    repeat (20) @(negedge clk);
    check("R10 no start", {61'h0, mdc, mdio_oe, r[0]}, 64'h0);
    hwrite(1'b1, 32'hFFFF_1234);
    hread(1'b1, r); check("R7 data upper zero", 64'(r), 64'h0000_1234);

    run_txn(1'b1, 5'd1, 5'd0, 16'h8001, 16'h0, 0);
    run_txn(1'b0, 5'd1, 5'd31, 16'h0, 16'hFFFF, 0);
    run_txn(1'b0, 5'd31, 5'd2, 16'h0, 16'h0001, 30);
    run_txn(1'b1, 5'd0, 5'd17, 16'hFFFF, 16'h0, 200);

    for (int i = 0; i < 12; i++) begin
      run_txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
              16'($urandom), 1 + int'($urandom % (128 * DIV_HALF - 4)));
    end

    check("R9 mdio stable while mdc high", 64'(viol), 64'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R3 actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule